// File: doc/BRIEF.md
# Memory Channel Initialization Sequencer

This block is a controller-side sequencer that takes a channel of several memory devices from reset to normal operation. It is started by a one-cycle `start_i` pulse. It then runs a fixed bring-up script, issuing one command at a time on a request port. A serial control engine or a packet issuer downstream takes each request and acknowledges it. The script has these steps, in order:

1. A second reset of every device.
2. A preload of the current-control registers to their midpoint.
3. A broadcast wake-up from powerdown.
4. A per-device fast-set command.
5. Six cycles that fill the 64-bit controller configuration word one field at a time.
6. A long broadcast current-control and temperature-calibration burst.
7. A fixed burst of refresh transactions.
8. A write/read probe of each device.
9. A final rewrite of each device's init register.

The configuration word is copied field by field from `cap_i`. That input already carries the worst-case value of each field across all devices on the channel, so every field is compatible with every device. When the script ends, `done_o` pulses for one cycle and the block waits for the next start.

Top module: `mem_chan_init_seq`

## Requirements
- R1: Out of reset and until `start_i` is seen, `cmd_valid_o`=0, `done_o`=0 and `cfg_o`=0.
- R2: A request stays valid with unchanged op, device, broadcast, address and data until `cmd_ack_i` is high at a clock edge. Exactly one command is consumed per acknowledged cycle.
- R3: Device IDs are visited in ascending order from 0 to N_DEV-1 in every per-device step. Step one sends each device op 1 (set-reset) and then op 2 (clear-reset), unicast.
- R4: Next, each device gets two op 3 (register write) commands: first to address 0x43, then to address 0x44. Both carry data (CC_MIN+CC_MAX)/2, which is 0x0040 by default.
- R5: Next comes one op 4 (powerdown exit) with broadcast flag 1 and device 0. Then each device gets op 5 (fast-set).
- R6: In the six cycles after the last fast-set is accepted, no request is valid. One field of `cfg_o` is copied from `cap_i` per cycle, in this order: offset [3:0], row/column timing [27:4], refresh [39:28], current-control interval [47:40], temperature interval [55:48], geometry [63:56]. Fields not yet written read 0.
- R7: Next come 128 groups of three op 6 (calibrate) followed by one op 7 (calibrate-and-sample), all broadcast. These are followed by one broadcast op 8 (temperature calibrate).
- R8: Exactly 192 broadcast op 9 (refresh) commands follow.
- R9: Each device then gets op 10 (memory write, data 0xA5C3) and then op 11 (memory read, data 0).
- R10: Last, each device gets op 3 to address 0x21 with data 0x00E5.
- R11: `done_o` is high for exactly the one cycle after the last acknowledge. `cfg_o` holds its value until the next start, which clears it.
- R12: `start_i` has no effect while a sequence is running.
- In every command, fields not named above (address, data) are 0. A broadcast command carries device 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts the script when idle |
| cap_i | input | 64 | Worst-case configuration values, in the `cfg_o` layout |
| cmd_ack_i | input | 1 | Downstream accepts the current request |
| cmd_valid_o | output | 1 | Request valid |
| cmd_op_o | output | 4 | Command code |
| cmd_dev_o | output | 2 | Target device ID |
| cmd_bcast_o | output | 1 | Broadcast flag |
| cmd_addr_o | output | 8 | Register address |
| cmd_data_o | output | 16 | Register or probe data |
| cfg_o | output | 64 | Controller configuration word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench compares the whole accepted command stream, entry by entry, against a list built from the requirements. The stream is run with and without acknowledge delay, so a counter that is off by one in the calibration or refresh burst, a wrong sub-command order or a skipped device shows up as a mismatch at a known index. The configuration fill is sampled in each of its six cycles, which exposes a field written out of order, early or with the wrong mask. A start pulse during a run and a second run with other capability values would expose a sequencer that restarts mid-stream or keeps stale configuration bits.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;
  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_SETR   = 4'd1,
    OP_CLRR   = 4'd2,
    OP_REGWR  = 4'd3,
    OP_PDNX   = 4'd4,
    OP_SETF   = 4'd5,
    OP_CAL    = 4'd6,
    OP_CALSAM = 4'd7,
    OP_TCAL   = 4'd8,
    OP_REF    = 4'd9,
    OP_MWR    = 4'd10,
    OP_MRD    = 4'd11
  } cmd_op_e;

  localparam int CFG_W   = 64;
  localparam int NUM_FLD = 6;
  localparam int FLD_LO [NUM_FLD] = '{0, 4, 28, 40, 48, 56};
  localparam int FLD_HI [NUM_FLD] = '{3, 27, 39, 47, 55, 63};
endpackage

// File: rtl/init_down_cnt.sv
module init_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

  // R7
  cnt_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !load_i |-> !last_o);
endmodule

// File: rtl/init_cfg_builder.sv
module init_cfg_builder
  import init_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [2:0]       fld_i,
  input  logic [CFG_W-1:0] cap_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] fld_mask [NUM_FLD];
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] sel_mask;

  for (genvar g = 0; g < NUM_FLD; g++) begin : g_mask
    localparam int LEN = FLD_HI[g] - FLD_LO[g] + 1;
    assign fld_mask[g] = ((CFG_W'(1) << LEN) - CFG_W'(1)) << FLD_LO[g];
  end

  always_comb begin
    sel_mask = '0;
    for (int i = 0; i < NUM_FLD; i++)
      if (fld_i == 3'(i)) sel_mask = fld_mask[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_q <= '0;
    else if (clr_i) cfg_q <= '0;
    else if (wr_i)  cfg_q <= (cfg_q & ~sel_mask) | (cap_i & sel_mask);
  end

  assign cfg_o = cfg_q;

  // R6
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !wr_i |=> $stable(cfg_o));
endmodule

// File: rtl/mem_chan_init_seq.sv
module mem_chan_init_seq
  import init_seq_pkg::*;
#(
  parameter int          N_DEV      = 4,
  parameter int          CAL_OPS    = 128,
  parameter int          REF_CNT    = 192,
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 16,
  parameter logic [7:0]  ADDR_CCA   = 8'h43,
  parameter logic [7:0]  ADDR_CCB   = 8'h44,
  parameter logic [7:0]  ADDR_INIT  = 8'h21,
  parameter logic [15:0] CC_MIN     = 16'h0010,
  parameter logic [15:0] CC_MAX     = 16'h0070,
  parameter logic [15:0] INIT_FINAL = 16'h00E5,
  parameter logic [15:0] PROBE_PAT  = 16'hA5C3,
  localparam int         DEV_W      = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [63:0]       cap_i,
  input  logic              cmd_ack_i,
  output logic              cmd_valid_o,
  output logic [3:0]        cmd_op_o,
  output logic [DEV_W-1:0]  cmd_dev_o,
  output logic              cmd_bcast_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic [63:0]       cfg_o,
  output logic              done_o
);
  localparam int CAL_W = $clog2(CAL_OPS + 1);
  localparam int REF_W = $clog2(REF_CNT + 1);
  localparam logic [16:0] CC_SUM = {1'b0, CC_MIN} + {1'b0, CC_MAX};
  localparam logic [15:0] CC_MID = CC_SUM[16:1];

  typedef enum logic [3:0] {
    S_IDLE, S_SETR, S_CLRR, S_CCA, S_CCB, S_PDNX, S_SETF, S_CFG,
    S_CAL, S_TCAL, S_REF, S_MWR, S_MRD, S_FIN, S_DONE
  } state_e;

  state_e           state_q;
  logic [DEV_W-1:0] dev_q;
  logic [2:0]       fld_q;
  logic [1:0]       sub_q;
  logic             acc, dev_last, cal_last, ref_last;
  logic             cal_load, cal_dec, ref_load, ref_dec;
  cmd_op_e          op;

  assign acc      = cmd_valid_o & cmd_ack_i;
  assign dev_last = (dev_q == DEV_W'(N_DEV - 1));

  always_comb begin
    cmd_valid_o = 1'b1;
    cmd_bcast_o = 1'b0;
    op          = OP_NONE;
    cmd_addr_o  = '0;
    cmd_data_o  = '0;
    unique case (state_q)
      S_SETR: op = OP_SETR;
      S_CLRR: op = OP_CLRR;
      S_CCA:  begin op = OP_REGWR; cmd_addr_o = ADDR_W'(ADDR_CCA); cmd_data_o = DATA_W'(CC_MID); end
      S_CCB:  begin op = OP_REGWR; cmd_addr_o = ADDR_W'(ADDR_CCB); cmd_data_o = DATA_W'(CC_MID); end
      S_PDNX: begin op = OP_PDNX; cmd_bcast_o = 1'b1; end
      S_SETF: op = OP_SETF;
      S_CAL:  begin op = (sub_q == 2'd3) ? OP_CALSAM : OP_CAL; cmd_bcast_o = 1'b1; end
      S_TCAL: begin op = OP_TCAL; cmd_bcast_o = 1'b1; end
      S_REF:  begin op = OP_REF; cmd_bcast_o = 1'b1; end
      S_MWR:  begin op = OP_MWR; cmd_data_o = DATA_W'(PROBE_PAT); end
      S_MRD:  op = OP_MRD;
      S_FIN:  begin op = OP_REGWR; cmd_addr_o = ADDR_W'(ADDR_INIT); cmd_data_o = DATA_W'(INIT_FINAL); end
      default: cmd_valid_o = 1'b0;
    endcase
  end

  assign cmd_op_o  = op;
  assign cmd_dev_o = cmd_bcast_o ? '0 : dev_q;
  assign done_o    = (state_q == S_DONE);

  // burst counters
  assign cal_load = (state_q == S_CFG) && (fld_q == 3'(NUM_FLD - 1));
  assign cal_dec  = (state_q == S_CAL) && acc && (sub_q == 2'd3) && !cal_last;
  assign ref_load = (state_q == S_TCAL) && acc;
  assign ref_dec  = (state_q == S_REF) && acc && !ref_last;

  init_down_cnt #(.W(CAL_W)) u_cal_cnt (
    .clk_i, .rst_ni, .load_i(cal_load), .val_i(CAL_W'(CAL_OPS - 1)),
    .dec_i(cal_dec), .last_o(cal_last)
  );

  init_down_cnt #(.W(REF_W)) u_ref_cnt (
    .clk_i, .rst_ni, .load_i(ref_load), .val_i(REF_W'(REF_CNT - 1)),
    .dec_i(ref_dec), .last_o(ref_last)
  );

  init_cfg_builder u_cfg (
    .clk_i, .rst_ni,
    .clr_i(state_q == S_IDLE && start_i),
    .wr_i (state_q == S_CFG),
    .fld_i(fld_q),
    .cap_i,
    .cfg_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      dev_q   <= '0;
      fld_q   <= '0;
      sub_q   <= '0;
    end else begin
      // per-device stepping on the last command of each device
      if (acc && (state_q inside {S_CLRR, S_CCB, S_SETF, S_MRD, S_FIN}))
        dev_q <= dev_last ? '0 : dev_q + 1'b1;
      unique case (state_q)
        S_IDLE: if (start_i) begin state_q <= S_SETR; dev_q <= '0; end
        S_SETR: if (acc) state_q <= S_CLRR;
        S_CLRR: if (acc) state_q <= dev_last ? S_CCA : S_SETR;
        S_CCA:  if (acc) state_q <= S_CCB;
        S_CCB:  if (acc) state_q <= dev_last ? S_PDNX : S_CCA;
        S_PDNX: if (acc) state_q <= S_SETF;
        S_SETF: if (acc) begin
                  if (dev_last) begin state_q <= S_CFG; fld_q <= '0; end
                end
        S_CFG:  if (fld_q == 3'(NUM_FLD - 1)) begin state_q <= S_CAL; sub_q <= '0; end
                else fld_q <= fld_q + 1'b1;
        S_CAL:  if (acc) begin
                  sub_q <= sub_q + 1'b1;
                  if (sub_q == 2'd3 && cal_last) state_q <= S_TCAL;
                end
        S_TCAL: if (acc) state_q <= S_REF;
        S_REF:  if (acc && ref_last) state_q <= S_MWR;
        S_MWR:  if (acc) state_q <= S_MRD;
        S_MRD:  if (acc) state_q <= dev_last ? S_FIN : S_MWR;
        S_FIN:  if (acc && dev_last) state_q <= S_DONE;
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ack_i |=> cmd_valid_o && $stable(cmd_op_o) &&
      $stable(cmd_dev_o) && $stable(cmd_addr_o) && $stable(cmd_data_o));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !cmd_valid_o);

  // R8
  ref_bcast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && (cmd_op_o == OP_REF) |-> cmd_bcast_o && (cmd_dev_o == '0));

  // R6
  cfg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && $past(cmd_valid_o) |-> $stable(cfg_o));

  // R12
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && start_i && !cmd_ack_i |=> $stable(cmd_op_o));
endmodule

// File: tb/mem_chan_init_seq_tb_top.sv
module mem_chan_init_seq_tb_top;
  localparam int N_DEV = 4;
  localparam int TOTAL = 2*N_DEV + 2*N_DEV + 1 + N_DEV + 128*4 + 1 + 192 + 2*N_DEV + N_DEV;
  localparam int IDX_CFG = 2*N_DEV + 2*N_DEV + 1 + N_DEV;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] cap_i = '0;
  logic        cmd_ack_i = 1'b0;
  logic        cmd_valid_o;
  logic [3:0]  cmd_op_o;
  logic [1:0]  cmd_dev_o;
  logic        cmd_bcast_o;
  logic [7:0]  cmd_addr_o;
  logic [15:0] cmd_data_o;
  logic [63:0] cfg_o;
  logic        done_o;

  int checks = 0;
  int failures = 0;

  logic [3:0]  e_op   [TOTAL];
  logic [1:0]  e_dev  [TOTAL];
  logic        e_bc   [TOTAL];
  logic [7:0]  e_addr [TOTAL];
  logic [15:0] e_data [TOTAL];
  string       e_req  [TOTAL];
  int          n_exp;

  always #2.5 clk_i = ~clk_i;

  mem_chan_init_seq dut_i (
    .clk_i, .rst_ni, .start_i, .cap_i, .cmd_ack_i, .cmd_valid_o, .cmd_op_o,
    .cmd_dev_o, .cmd_bcast_o, .cmd_addr_o, .cmd_data_o, .cfg_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] op, input int dev, input bit bc,
                      input logic [7:0] addr, input logic [15:0] data, input string req);
    e_op[n_exp] = op; e_dev[n_exp] = 2'(dev); e_bc[n_exp] = bc;
    e_addr[n_exp] = addr; e_data[n_exp] = data; e_req[n_exp] = req;
    n_exp++;
  endtask

  task automatic build_expected();
    n_exp = 0;
    for (int d = 0; d < N_DEV; d++) begin
      push(4'd1, d, 0, 8'h00, 16'h0000, "R3");
      push(4'd2, d, 0, 8'h00, 16'h0000, "R3");
    end
    for (int d = 0; d < N_DEV; d++) begin
      push(4'd3, d, 0, 8'h43, 16'h0040, "R4");
      push(4'd3, d, 0, 8'h44, 16'h0040, "R4");
    end
    push(4'd4, 0, 1, 8'h00, 16'h0000, "R5");
    for (int d = 0; d < N_DEV; d++) push(4'd5, d, 0, 8'h00, 16'h0000, "R5");
    for (int k = 0; k < 128; k++) begin
      for (int j = 0; j < 3; j++) push(4'd6, 0, 1, 8'h00, 16'h0000, "R7");
      push(4'd7, 0, 1, 8'h00, 16'h0000, "R7");
    end
    push(4'd8, 0, 1, 8'h00, 16'h0000, "R7");
    for (int k = 0; k < 192; k++) push(4'd9, 0, 1, 8'h00, 16'h0000, "R8");
    for (int d = 0; d < N_DEV; d++) begin
      push(4'd10, d, 0, 8'h00, 16'hA5C3, "R9");
      push(4'd11, d, 0, 8'h00, 16'h0000, "R9");
    end
    for (int d = 0; d < N_DEV; d++) push(4'd3, d, 0, 8'h21, 16'h00E5, "R10");
  endtask

  function automatic logic [63:0] cfg_mask(input int nfld);
    int hi [6] = '{3, 27, 39, 47, 55, 63};
    logic [63:0] m = '0;
    for (int i = 0; i < nfld; i++) m = (64'd1 << (hi[i] + 1)) - 64'd1;
    return m;
  endfunction

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk(cmd_valid_o == 1'b0, "R1", "valid after reset", 64'(cmd_valid_o), 0);
    chk(done_o == 1'b0, "R1", "done after reset", 64'(done_o), 0);
    chk(cfg_o == '0, "R1", "cfg after reset", cfg_o, 0);
    repeat (10) @(negedge clk_i);
    chk(cmd_valid_o == 1'b0, "R1", "valid without start", 64'(cmd_valid_o), 0);
  endtask

  // one full script; gap = idle cycles before each ack, mid_start = index for a stray start
  task automatic t_run(input int gap, input logic [63:0] cap, input int mid_start);
    int idx = 0;
    cap_i = cap;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(cfg_o == '0, "R11", "cfg cleared by start", cfg_o, 0);
    chk(cmd_valid_o == 1'b1, "R3", "first request valid", 64'(cmd_valid_o), 1);
    while (idx < TOTAL) begin
      if (cmd_valid_o) begin
        repeat (gap) @(negedge clk_i);
        chk(cmd_valid_o && cmd_op_o == e_op[idx], e_req[idx], $sformatf("op @%0d", idx),
            64'(cmd_op_o), 64'(e_op[idx]));
        chk(cmd_dev_o == e_dev[idx] && cmd_bcast_o == e_bc[idx], e_req[idx],
            $sformatf("dev/bcast @%0d", idx), {cmd_bcast_o, cmd_dev_o}, {e_bc[idx], e_dev[idx]});
        chk(cmd_addr_o == e_addr[idx] && cmd_data_o == e_data[idx], e_req[idx],
            $sformatf("addr/data @%0d", idx), {cmd_addr_o, cmd_data_o}, {e_addr[idx], e_data[idx]});
        chk(done_o == 1'b0, "R11", "no early done", 64'(done_o), 0);
        cmd_ack_i = 1'b1;
        @(negedge clk_i);
        cmd_ack_i = 1'b0;
        idx++;
        if (idx == IDX_CFG) begin
          for (int k = 0; k < 6; k++) begin
            if (k > 0) @(negedge clk_i);
            chk(cmd_valid_o == 1'b0, "R6", $sformatf("quiet in cfg cycle %0d", k),
                64'(cmd_valid_o), 0);
            chk(cfg_o == (cap & cfg_mask(k)), "R6", $sformatf("cfg after %0d fields", k),
                cfg_o, cap & cfg_mask(k));
          end
          @(negedge clk_i);
          chk(cfg_o == cap, "R6", "cfg complete", cfg_o, cap);
        end
        if (idx == mid_start) begin
          start_i = 1'b1;   // R12: must not disturb the stream
          @(negedge clk_i);
          start_i = 1'b0;
        end
      end else begin
        @(negedge clk_i);
      end
    end
    chk(done_o == 1'b1, "R11", "done after last ack", 64'(done_o), 1);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R11", "done one cycle", 64'(done_o), 0);
    chk(cmd_valid_o == 1'b0, "R11", "idle after done", 64'(cmd_valid_o), 0);
    repeat (4) @(negedge clk_i);
    chk(cfg_o == cap, "R11", "cfg held after done", cfg_o, cap);
    chk(cmd_valid_o == 1'b0, "R1", "no restart without start", 64'(cmd_valid_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    build_expected();
    t_reset();
    t_run(0, 64'h9ABC_DEF0_1234_5678, -1);
    t_run(2, 64'h1F2E_3D4C_5B6A_7988, 200);   // R12 stray start mid-run
    t_run(1, 64'hFFFF_FFFF_FFFF_FFFF, 30);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule